// File: doc/BRIEF.md
# Hybrid Redundancy and Voltage-Scaling Thermal Policy Controller

This controller sits beside a processor core that can run a program as a pair of redundant threads for soft-error detection. Each time a new peak-temperature reading arrives, it decides two things. The first is whether the duplicate thread may keep running. The second is whether the voltage/frequency scaler should be asked to slow the core down. A reading arrives once per evaluation interval, typically every 10,000 core cycles, and is marked by a one-cycle valid strobe. Each reading is compared with a threshold supplied at the same time.

The policy reacts in two steps. When a reading first exceeds the threshold, the controller drops only the duplicate thread, which cools the core at no cost in clock speed. If the core stays hot for a set number of consecutive readings, the controller also engages voltage scaling. In the same cycle it pulses a strobe that tells the scaler to take its scaling factor from the current reading. Any reading at or below the threshold ends both measures together and restarts redundant execution.

After reset, a warmup phase of a set number of readings keeps redundancy on and ignores the temperature. One further interval runs redundantly before the first reading is judged. A status output gives the current run length of over-threshold readings.

Top module: `hybrid_thermal_policy`

## Requirements
- R1: While reset is held, and in the cycle after it is released, redundantEn is 1, scaleEngage is 0, scaleLatch is 0 and violationCount is 0.
- R2: The first WARMUP_SAMPLES readings (sampleValid high) after reset are ignored whatever their temperature: redundantEn stays 1, scaleEngage stays 0 and violationCount stays 0.
- R3: A reading counts as a violation only if maxTemp is strictly greater than threshold, compared as unsigned values. A reading equal to the threshold is not a violation. Reading WARMUP_SAMPLES+1 is the first reading that is judged.
- R4: When redundancy is on and warmup is over, a violating reading clears redundantEn in the next cycle, leaves scaleEngage at 0 and sets violationCount to 1.
- R5: A non-violating reading that arrives before scaling has engaged sets redundantEn back to 1 and clears violationCount, and scaleEngage never rises.
- R6: When ESCALATE_SAMPLES consecutive readings violate, scaleEngage rises in the cycle after the last of them. scaleLatch is 1 for exactly that one cycle, and redundantEn stays 0.
- R7: While scaling is engaged, each further violating reading keeps scaleEngage at 1 and redundantEn at 0 without another scaleLatch pulse. violationCount goes up by one per reading and saturates at 2**CNT_W-1.
- R8: A non-violating reading while scaling is engaged clears scaleEngage, sets redundantEn and clears violationCount, all in the same next cycle.
- R9: In a cycle with sampleValid low, none of redundantEn, scaleEngage or violationCount changes, and scaleLatch is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new temperature reading |
| maxTemp | input | TEMP_W | Hottest structure temperature in the reading (unsigned) |
| threshold | input | TEMP_W | Temperature limit (unsigned) |
| redundantEn | output | 1 | Duplicate-thread execution permitted |
| scaleEngage | output | 1 | Request to the voltage/frequency scaler to be active |
| scaleLatch | output | 1 | One-cycle pulse: scaler takes its factor from the current reading |
| violationCount | output | CNT_W | Consecutive over-threshold readings, saturating |

## Verification
The bench targets these corner cases:
- A reading exactly equal to the threshold. A design with a `>=` compare would drop redundancy there.
- Hot readings during warmup and in the first judged reading. An off-by-one warmup count would act one reading early or late.
- A hot run that is broken one reading short of escalation. A design that failed to clear its counter on the way back would escalate too soon on the next hot run.
- Long hot runs after scaling has engaged. These catch a repeated latch pulse and a counter that wraps instead of saturating.
- Idle cycles with hot inputs, and a reset in the middle of the run. A design that ignored sampleValid would change state on them, and a missing reset term would skip warmup.

// File: rtl/thermal_policy_pkg.sv
package thermal_policy_pkg;

  typedef enum logic [1:0] {
    ST_WARMUP      = 2'd0,
    ST_REDUNDANT   = 2'd1,
    ST_SINGLE_WAIT = 2'd2,
    ST_SINGLE_DVS  = 2'd3
  } policyState_t;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic incWarm;   // advance warmup reading counter
    logic clrViol;   // zero the consecutive-violation counter
    logic incViol;   // bump the consecutive-violation counter (saturating)
    logic latchReq;  // emit the scaling-factor latch pulse next cycle
  } ctlStrobe_t;

endpackage

// File: rtl/thermal_policy_dp.sv
module thermal_policy_dp
  import thermal_policy_pkg::*;
#(
  parameter int TEMP_W           = 8,
  parameter int CNT_W            = 4,
  parameter int WARMUP_SAMPLES   = 4,
  parameter int ESCALATE_SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] maxTemp,
  input  logic [TEMP_W-1:0] threshold,
  input  ctlStrobe_t        ctl,
  output logic              hot,
  output logic              warmLast,
  output logic              escalateNext,
  output logic [CNT_W-1:0]  violationCount,
  output logic              scaleLatch
);

  localparam int WARM_W = (WARMUP_SAMPLES < 2) ? 1 : $clog2(WARMUP_SAMPLES + 1);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARMUP_SAMPLES - 1);
  localparam logic [CNT_W-1:0]  ESC_LAST  = CNT_W'(ESCALATE_SAMPLES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

  logic [WARM_W-1:0] warmCnt;
  logic [CNT_W-1:0]  violCnt;

  // Strictly greater: equality is not a violation
  assign hot          = maxTemp > threshold;
  assign warmLast     = warmCnt == WARM_LAST;
  assign escalateNext = violCnt == ESC_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (ctl.incWarm) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violCnt <= '0;
    end else if (ctl.clrViol) begin
      violCnt <= '0;
    end else if (ctl.incViol && violCnt != CNT_MAX) begin
      violCnt <= violCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scaleLatch <= 1'b0;
    end else begin
      scaleLatch <= ctl.latchReq;
    end
  end

  assign violationCount = violCnt;

endmodule

// File: rtl/thermal_policy_ctl.sv
module thermal_policy_ctl
  import thermal_policy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       hot,
  input  logic       warmLast,
  input  logic       escalateNext,
  output ctlStrobe_t ctl,
  output logic       redundantEn,
  output logic       scaleEngage
);

  policyState_t state, stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (sampleValid) begin
      unique case (state)
        ST_WARMUP: begin
          if (warmLast) stateNext = ST_REDUNDANT;
          else          ctl.incWarm = 1'b1;
        end
        ST_REDUNDANT: begin
          if (hot) begin
            stateNext   = ST_SINGLE_WAIT;
            ctl.incViol = 1'b1;
          end else begin
            ctl.clrViol = 1'b1;
          end
        end
        ST_SINGLE_WAIT: begin
          if (hot) begin
            ctl.incViol = 1'b1;
            if (escalateNext) begin
              stateNext    = ST_SINGLE_DVS;
              ctl.latchReq = 1'b1;
            end
          end else begin
            stateNext   = ST_REDUNDANT;
            ctl.clrViol = 1'b1;
          end
        end
        ST_SINGLE_DVS: begin
          if (hot) begin
            ctl.incViol = 1'b1;
          end else begin
            stateNext   = ST_REDUNDANT;
            ctl.clrViol = 1'b1;
          end
        end
        default: stateNext = ST_WARMUP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WARMUP;
    else       state <= stateNext;
  end

  assign redundantEn = (state == ST_WARMUP) || (state == ST_REDUNDANT);
  assign scaleEngage = state == ST_SINGLE_DVS;

endmodule

// File: rtl/hybrid_thermal_policy.sv
module hybrid_thermal_policy
  import thermal_policy_pkg::*;
#(
  parameter int TEMP_W           = 8,
  parameter int CNT_W            = 4,
  parameter int WARMUP_SAMPLES   = 4,
  parameter int ESCALATE_SAMPLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] maxTemp,
  input  logic [TEMP_W-1:0] threshold,
  output logic              redundantEn,
  output logic              scaleEngage,
  output logic              scaleLatch,
  output logic [CNT_W-1:0]  violationCount
);

  ctlStrobe_t ctl;
  logic       hot;
  logic       warmLast;
  logic       escalateNext;

  thermal_policy_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .hot          (hot),
    .warmLast     (warmLast),
    .escalateNext (escalateNext),
    .ctl          (ctl),
    .redundantEn  (redundantEn),
    .scaleEngage  (scaleEngage)
  );

  thermal_policy_dp #(
    .TEMP_W           (TEMP_W),
    .CNT_W            (CNT_W),
    .WARMUP_SAMPLES   (WARMUP_SAMPLES),
    .ESCALATE_SAMPLES (ESCALATE_SAMPLES)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .maxTemp        (maxTemp),
    .threshold      (threshold),
    .ctl            (ctl),
    .hot            (hot),
    .warmLast       (warmLast),
    .escalateNext   (escalateNext),
    .violationCount (violationCount),
    .scaleLatch     (scaleLatch)
  );

endmodule

// File: rtl/hybrid_thermal_policy_checker.sv
module hybrid_thermal_policy_checker #(
  parameter int TEMP_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [TEMP_W-1:0] maxTemp,
  input logic [TEMP_W-1:0] threshold,
  input logic              redundantEn,
  input logic              scaleEngage,
  input logic              scaleLatch,
  input logic [CNT_W-1:0]  violationCount
);

  AST_SCALE_EXCLUDES_REDUNDANCY: assert property (@(posedge clk) disable iff (!rstN)
    scaleEngage |-> !redundantEn); // R7

  AST_LATCH_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    scaleLatch |-> (scaleEngage && !$past(scaleEngage))); // R6

  AST_LATCH_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    scaleLatch |=> !scaleLatch); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(redundantEn) && $stable(scaleEngage) && $stable(violationCount))); // R9

  AST_DROP_NEEDS_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(redundantEn) |-> ($past(sampleValid) && ($past(maxTemp) > $past(threshold)))); // R4

  AST_RELEASE_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scaleEngage) |-> (redundantEn && violationCount == '0)); // R8

endmodule

bind hybrid_thermal_policy hybrid_thermal_policy_checker #(
  .TEMP_W (TEMP_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/hybrid_thermal_policy_bench.sv
`timescale 1ns/1ps
module hybrid_thermal_policy_bench;

  localparam int TEMP_W = 8;
  localparam int CNT_W  = 4;
  localparam int WARM   = 4;
  localparam int ESC    = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleValid = 1'b0;
  logic [TEMP_W-1:0] maxTemp = '0;
  logic [TEMP_W-1:0] threshold = '0;
  logic              redundantEn;
  logic              scaleEngage;
  logic              scaleLatch;
  logic [CNT_W-1:0]  violationCount;

  always #2.5 clk = ~clk;

  hybrid_thermal_policy #(
    .TEMP_W(TEMP_W), .CNT_W(CNT_W), .WARMUP_SAMPLES(WARM), .ESCALATE_SAMPLES(ESC)
  ) u_hybrid_thermal_policy (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .maxTemp(maxTemp),
    .threshold(threshold), .redundantEn(redundantEn), .scaleEngage(scaleEngage),
    .scaleLatch(scaleLatch), .violationCount(violationCount)
  );

  // Behavioural reference: mode 0 warmup, 1 dual, 2 single, 3 single+scaling
  int mode, seen, run;
  bit expLatch;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  task automatic modelReset();
    mode = 0; seen = 0; run = 0; expLatch = 0;
  endtask

  task automatic modelStep(input bit v, input int t, input int th);
    expLatch = 0;
    if (!v) return;
    if (mode == 0) begin
      seen++;
      if (seen == WARM) mode = 1;
    end else if (t > th) begin
      if (run < CMAX) run++;
      if (mode == 1) mode = 2;
      else if (mode == 2 && run == ESC) begin mode = 3; expLatch = 1; end
    end else begin
      mode = 1; run = 0;
    end
  endtask

  task automatic compare(input string tag);
    bit eRed, eEng;
    eRed = (mode <= 1);
    eEng = (mode == 3);
    vectors++;
    if (redundantEn !== eRed) begin
      miscompares++;
      $display("FAIL %s redundantEn actual=%0b expected=%0b", tag, redundantEn, eRed);
    end
    if (scaleEngage !== eEng) begin
      miscompares++;
      $display("FAIL %s scaleEngage actual=%0b expected=%0b", tag, scaleEngage, eEng);
    end
    if (scaleLatch !== expLatch) begin
      miscompares++;
      $display("FAIL %s scaleLatch actual=%0b expected=%0b", tag, scaleLatch, expLatch);
    end
    if (violationCount !== CNT_W'(run)) begin
      miscompares++;
      $display("FAIL %s violationCount actual=%0d expected=%0d", tag, violationCount, run);
    end
  endtask

  task automatic step(input bit v, input int t, input int th, input string tag);
    @(negedge clk);
    sampleValid = v; maxTemp = TEMP_W'(t); threshold = TEMP_W'(th);
    @(posedge clk);
    modelStep(v, t, th);
    #1;
    compare(tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; sampleValid = 0;
    modelReset();
    #1 compare("R1");
    @(negedge clk);
    #1 compare("R1");
    @(negedge clk);
    rstN = 1;
    @(posedge clk); #1 compare("R1");
  endtask

  initial begin
    modelReset();
    doReset();
    // Idle with hot temperature: no effect (R9)
    for (int i = 0; i < 3; i++) step(0, 200, 80, "R9");
    // Warmup readings ignored even when hot (R2)
    for (int i = 0; i < WARM; i++) step(1, 200, 80, "R2");
    // First judged reading exactly at threshold (R3)
    step(1, 80, 80, "R3");
    step(1, 81, 80, "R4");
    step(0, 10, 80, "R9");
    step(1, 79, 80, "R5");
    // Hot run broken one short of escalation (R5)
    step(1, 120, 80, "R4");
    step(1, 120, 80, "R5");
    step(1, 80, 80, "R5");
    step(1, 90, 80, "R4");
    // Escalation (R6)
    step(1, 90, 80, "R6");
    step(1, 90, 80, "R6");
    step(0, 90, 80, "R9");
    // Stay hot: saturate, no repeat latch (R7)
    for (int i = 0; i < 20; i++) step(1, 255, 0, "R7");
    step(0, 0, 255, "R9");
    step(1, 5, 5, "R8");
    step(1, 6, 5, "R4");
    // Mid-run reset restarts warmup (R1, R2)
    doReset();
    for (int i = 0; i < WARM; i++) step(1, 255, 1, "R2");
    step(1, 255, 1, "R3");
    step(1, 255, 1, "R6");
    step(1, 255, 1, "R6");
    step(1, 0, 1, "R8");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule